// File: doc/BRIEF.md
# Dual-Port Control Register Bank

This block holds the 64-bit control and status registers of a processor-side bridge unit. Software reaches it along two paths. A service port names a register directly by its word index. A memory-mapped window port carries a byte address. That address is turned into a word index and then moved up by a fixed ten words. In this way the window sees only the upper part of the register space. The bank also holds the base register that enables and places that window. The block drives the base and the enable out to the address decoder around it.

The bank holds several kinds of register. A fault register has alias indices that AND or OR the write data into it. A control register has alias indices that set or clear bits. An interrupt status register follows hardware inputs and cannot be written. There are two base registers with fixed write masks and a few plain storage words. Indices the bank does not implement read as all ones and raise a flag. Writes to them change nothing.

Each request port uses a valid/ready handshake. The service port never stalls. The window port is held off (ready low) in any cycle in which the service port presents a request, so the service port wins every tie. A requester must keep valid and its payload steady until ready is seen. Exactly one request is accepted per cycle. Its response is a single-cycle pulse on the cycle after acceptance. The response cannot be stalled.

Top module: `bridge_csr_bank`

## Requirements
- R1: `svc_req_ready` is always 1. `win_req_ready` equals NOT `svc_req_valid`. Every accepted request gives exactly one `rsp_valid` pulse in the next cycle, with `rsp_port` 0 for the service port and 1 for the window. With no acceptance, `rsp_valid` stays low.
- R2: A window byte address A selects word index (A>>3)+0x0A. Its low three bits are ignored. A computed index of 0x20 or above is unimplemented (see R8).
- R3: Index 0x00 is the fault register and is read/write. A write to 0x01 stores fault AND data. A write to 0x02 stores fault OR data.
- R4: Index 0x0E is the control register and is written directly. A write to 0x12 sets the data's one bits. A write to 0x13 clears them.
- R5: Index 0x0A (base) is written only by the service port. A window write there leaves it unchanged and returns `rsp_err`=1.
- R6: A base write keeps only bit 0 and mask 0x0003_FFFF_FFF0_0000. A write to index 0x0B keeps only mask 0x0003_FFFF_0000_0000.
- R7: Index 0x15 reads `irq_src` as held one clock earlier, placed at bits 36:32, with all other bits zero. Writes there change nothing and return `rsp_err`=1.
- R8: Some reads return 64'hFFFF_FFFF_FFFF_FFFF with `rsp_unimp`=1. These are reads of an index not listed in R3 to R7 or R12, including the alias indices 0x01, 0x02, 0x12 and 0x13. A write to an unlisted index returns `rsp_unimp`=1 and changes no register. Write responses carry `rsp_rdata`=0.
- R9: `win_enable` is base bit 0 and `win_base` is base AND 0x0003_FFFF_FFF0_0000. Both change in the cycle of the response to the write.
- R10: `ctl_win_toggle` pulses for one cycle, together with the response, when a write through 0x0E, 0x12 or 0x13 changes control bit 62.
- R11: After reset, base holds 0x0003_FFFE_8000_0001 and every other register is zero. `rsp_valid` and `ctl_win_toggle` are low.
- R12: Indices 0x06, 0x07, 0x0F and 0x14 are plain 64-bit read/write words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_req_valid | input | 1 | Service port request valid |
| svc_req_ready | output | 1 | Service port ready |
| svc_req_write | input | 1 | Service request is a write |
| svc_req_index | input | 5 | Service word index |
| svc_req_wdata | input | 64 | Service write data |
| win_req_valid | input | 1 | Window request valid |
| win_req_ready | output | 1 | Window ready |
| win_req_write | input | 1 | Window request is a write |
| win_req_addr | input | 8 | Window byte address |
| win_req_wdata | input | 64 | Window write data |
| irq_src | input | 5 | Interrupt source levels |
| rsp_valid | output | 1 | Response pulse |
| rsp_port | output | 1 | Port of the response, 1 = window |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Write refused |
| rsp_unimp | output | 1 | Unimplemented index |
| win_enable | output | 1 | Window enable |
| win_base | output | 64 | Window base address |
| ctl_win_toggle | output | 1 | Control bit 62 changed |

## Verification
A request is accepted on a rising edge. Its response fields, the toggle pulse and any new window enable or base are all registered on that same edge. So each result is due exactly one cycle after acceptance. The bench drives requests on falling edges and reads every result on the falling edge right after the accepting edge. This holds for the tie case too: the window request there is accepted one edge later and checked one falling edge later. Interrupt inputs are changed at least one full clock before the read that is meant to see them.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
  localparam int unsigned IX_FAULT     = 'h00;
  localparam int unsigned IX_FAULT_AND = 'h01;
  localparam int unsigned IX_FAULT_OR  = 'h02;
  localparam int unsigned IX_BASE      = 'h0A;
  localparam int unsigned IX_BASE2     = 'h0B;
  localparam int unsigned IX_CTL       = 'h0E;
  localparam int unsigned IX_CTL_SET   = 'h12;
  localparam int unsigned IX_CTL_CLR   = 'h13;
  localparam int unsigned IX_STAT      = 'h15;
  localparam int unsigned SPACE        = 'h20;
  localparam int unsigned WIN_OFS      = 'h0A;
  localparam int unsigned CTL_WIN_BIT  = 62;
  localparam int unsigned PLAIN_N      = 4;
  localparam int unsigned SLOT_W       = $clog2(PLAIN_N);

  function automatic int unsigned plain_index(int unsigned slot);
    case (slot)
      0:       return 'h06;
      1:       return 'h07;
      2:       return 'h0F;
      default: return 'h14;
    endcase
  endfunction

  typedef enum logic [3:0] {
    K_NONE, K_FAULT, K_FAULT_AND, K_FAULT_OR, K_PLAIN,
    K_BASE, K_BASE2, K_CTL, K_CTL_SET, K_CTL_CLR, K_STAT
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [SLOT_W-1:0] slot;
  } dec_t;
endpackage

// File: rtl/bcb_port_arb.sv
module bcb_port_arb #(
  parameter int IDX_W = 5,
  parameter int AW    = 8,
  parameter int DW    = 64,
  localparam int EXT_W = ((IDX_W > AW - 3) ? IDX_W : AW - 3) + 1
) (
  input  logic             svc_valid,
  input  logic             svc_write,
  input  logic [IDX_W-1:0] svc_index,
  input  logic [DW-1:0]    svc_wdata,
  input  logic             win_valid,
  input  logic             win_write,
  input  logic [AW-1:0]    win_addr,
  input  logic [DW-1:0]    win_wdata,
  output logic             svc_ready,
  output logic             win_ready,
  output logic             acc,
  output logic             acc_write,
  output logic             acc_from_win,
  output logic [EXT_W-1:0] acc_idx,
  output logic [DW-1:0]    acc_wdata
);
  logic [EXT_W-1:0] win_idx;
  logic             unused_lo;

  assign unused_lo = ^win_addr[2:0];
  assign win_idx   = EXT_W'(win_addr[AW-1:3]) + EXT_W'(bcb_pkg::WIN_OFS);

  assign svc_ready    = 1'b1;
  assign win_ready    = ~svc_valid;
  assign acc          = svc_valid | win_valid;
  assign acc_from_win = ~svc_valid;
  assign acc_write    = svc_valid ? svc_write : win_write;
  assign acc_idx      = svc_valid ? EXT_W'(svc_index) : win_idx;
  assign acc_wdata    = svc_valid ? svc_wdata : win_wdata;
endmodule

// File: rtl/bcb_decode.sv
module bcb_decode #(
  parameter int EXT_W = 6
) (
  input  logic [EXT_W-1:0] idx,
  output bcb_pkg::dec_t    dec
);
  import bcb_pkg::*;
  int unsigned iv;

  always_comb begin
    iv       = 32'(idx);
    dec.kind = K_NONE;
    dec.slot = '0;
    if (iv < SPACE) begin
      case (iv)
        IX_FAULT:     dec.kind = K_FAULT;
        IX_FAULT_AND: dec.kind = K_FAULT_AND;
        IX_FAULT_OR:  dec.kind = K_FAULT_OR;
        IX_BASE:      dec.kind = K_BASE;
        IX_BASE2:     dec.kind = K_BASE2;
        IX_CTL:       dec.kind = K_CTL;
        IX_CTL_SET:   dec.kind = K_CTL_SET;
        IX_CTL_CLR:   dec.kind = K_CTL_CLR;
        IX_STAT:      dec.kind = K_STAT;
        default:      dec.kind = K_NONE;
      endcase
      for (int s = 0; s < PLAIN_N; s++) begin
        if (iv == plain_index(s)) begin
          dec.kind = K_PLAIN;
          dec.slot = SLOT_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/bcb_regs.sv
module bcb_regs #(
  parameter int          DW          = 64,
  parameter int          NIRQ        = 5,
  parameter int          IRQ_LSB     = 32,
  parameter logic [63:0] ADDR_MASK   = 64'h0003_FFFF_FFF0_0000,
  parameter logic [63:0] BASE2_MASK  = 64'h0003_FFFF_0000_0000,
  parameter logic [63:0] BASE_INIT   = 64'h0003_FFFE_8000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            acc_write,
  input  logic            acc_from_win,
  input  bcb_pkg::dec_t   dec,
  input  logic [DW-1:0]   wdata,
  input  logic [NIRQ-1:0] irq_src,
  output logic [DW-1:0]   rd_data,
  output logic            rd_err,
  output logic            rd_unimp,
  output logic [DW-1:0]   base_q,
  output logic            toggle_q
);
  import bcb_pkg::*;
  localparam logic [DW-1:0] BASE_KEEP = DW'(ADDR_MASK) | DW'(1);

  logic [DW-1:0] fault_q, ctl_q, base2_q, stat_q;
  logic [DW-1:0] fault_d, ctl_d, base_d, base2_d;
  logic [DW-1:0] plain_q [PLAIN_N];
  logic          wr;

  assign wr = acc & acc_write;

  always_comb begin
    fault_d = fault_q;
    ctl_d   = ctl_q;
    base_d  = base_q;
    base2_d = base2_q;
    if (wr) begin
      case (dec.kind)
        K_FAULT:     fault_d = wdata;
        K_FAULT_AND: fault_d = fault_q & wdata;
        K_FAULT_OR:  fault_d = fault_q | wdata;
        K_CTL:       ctl_d   = wdata;
        K_CTL_SET:   ctl_d   = ctl_q | wdata;
        K_CTL_CLR:   ctl_d   = ctl_q & ~wdata;
        K_BASE:      if (!acc_from_win) base_d = wdata & BASE_KEEP;
        K_BASE2:     base2_d = wdata & DW'(BASE2_MASK);
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q  <= '0;
      ctl_q    <= '0;
      base_q   <= DW'(BASE_INIT) & BASE_KEEP;
      base2_q  <= '0;
      stat_q   <= '0;
      toggle_q <= 1'b0;
    end else begin
      fault_q  <= fault_d;
      ctl_q    <= ctl_d;
      base_q   <= base_d;
      base2_q  <= base2_d;
      stat_q   <= DW'(irq_src) << IRQ_LSB;
      toggle_q <= ctl_d[CTL_WIN_BIT] ^ ctl_q[CTL_WIN_BIT];
    end
  end

  for (genvar s = 0; s < PLAIN_N; s++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rst_n) plain_q[s] <= '0;
      else if (wr && dec.kind == K_PLAIN && dec.slot == SLOT_W'(s)) plain_q[s] <= wdata;
    end
  end

  always_comb begin
    rd_data  = '0;
    rd_err   = 1'b0;
    rd_unimp = 1'b0;
    if (acc_write) begin
      rd_err   = (dec.kind == K_BASE && acc_from_win) || dec.kind == K_STAT;
      rd_unimp = dec.kind == K_NONE;
    end else begin
      case (dec.kind)
        K_FAULT: rd_data = fault_q;
        K_PLAIN: rd_data = plain_q[dec.slot];
        K_BASE:  rd_data = base_q;
        K_BASE2: rd_data = base2_q;
        K_CTL:   rd_data = ctl_q;
        K_STAT:  rd_data = stat_q;
        default: begin
          rd_data  = '1;
          rd_unimp = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bridge_csr_bank.sv
module bridge_csr_bank #(
  parameter int          IDX_W      = 5,
  parameter int          AW         = 8,
  parameter int          DW         = 64,
  parameter int          NIRQ       = 5,
  parameter int          IRQ_LSB    = 32,
  parameter logic [63:0] ADDR_MASK  = 64'h0003_FFFF_FFF0_0000,
  parameter logic [63:0] BASE2_MASK = 64'h0003_FFFF_0000_0000,
  parameter logic [63:0] BASE_INIT  = 64'h0003_FFFE_8000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_req_valid,
  output logic             svc_req_ready,
  input  logic             svc_req_write,
  input  logic [IDX_W-1:0] svc_req_index,
  input  logic [DW-1:0]    svc_req_wdata,
  input  logic             win_req_valid,
  output logic             win_req_ready,
  input  logic             win_req_write,
  input  logic [AW-1:0]    win_req_addr,
  input  logic [DW-1:0]    win_req_wdata,
  input  logic [NIRQ-1:0]  irq_src,
  output logic             rsp_valid,
  output logic             rsp_port,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic             rsp_unimp,
  output logic             win_enable,
  output logic [DW-1:0]    win_base,
  output logic             ctl_win_toggle
);
  localparam int EXT_W = ((IDX_W > AW - 3) ? IDX_W : AW - 3) + 1;

  logic             acc, acc_write, acc_from_win;
  logic [EXT_W-1:0] acc_idx;
  logic [DW-1:0]    acc_wdata, rd_data, base_q;
  logic             rd_err, rd_unimp;
  bcb_pkg::dec_t    dec;

  bcb_port_arb #(.IDX_W(IDX_W), .AW(AW), .DW(DW)) u_arb (
    .svc_valid(svc_req_valid), .svc_write(svc_req_write),
    .svc_index(svc_req_index), .svc_wdata(svc_req_wdata),
    .win_valid(win_req_valid), .win_write(win_req_write),
    .win_addr(win_req_addr), .win_wdata(win_req_wdata),
    .svc_ready(svc_req_ready), .win_ready(win_req_ready),
    .acc(acc), .acc_write(acc_write), .acc_from_win(acc_from_win),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata)
  );

  bcb_decode #(.EXT_W(EXT_W)) u_dec (.idx(acc_idx), .dec(dec));

  bcb_regs #(
    .DW(DW), .NIRQ(NIRQ), .IRQ_LSB(IRQ_LSB), .ADDR_MASK(ADDR_MASK),
    .BASE2_MASK(BASE2_MASK), .BASE_INIT(BASE_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_write(acc_write),
    .acc_from_win(acc_from_win), .dec(dec), .wdata(acc_wdata),
    .irq_src(irq_src), .rd_data(rd_data), .rd_err(rd_err),
    .rd_unimp(rd_unimp), .base_q(base_q), .toggle_q(ctl_win_toggle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      rsp_unimp <= 1'b0;
    end else begin
      rsp_valid <= acc;
      rsp_port  <= acc_from_win;
      rsp_rdata <= acc ? rd_data : '0;
      rsp_err   <= acc & rd_err;
      rsp_unimp <= acc & rd_unimp;
    end
  end

  assign win_enable = base_q[0];
  assign win_base   = base_q & DW'(ADDR_MASK);
endmodule

// File: rtl/bcb_checker.sv
module bcb_checker #(
  parameter int IDX_W = 5,
  parameter int AW    = 8,
  parameter int DW    = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          svc_req_valid,
  input logic          svc_req_ready,
  input logic          svc_req_write,
  input logic          win_req_valid,
  input logic          win_req_ready,
  input logic          win_req_write,
  input logic [AW-1:0] win_req_addr,
  input logic          rsp_valid,
  input logic          rsp_port,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic          rsp_unimp,
  input logic          win_enable,
  input logic [DW-1:0] win_base,
  input logic          ctl_win_toggle
);
  logic svc_acc, win_acc, any_acc, acc_wr;
  assign svc_acc = svc_req_valid & svc_req_ready;
  assign win_acc = win_req_valid & win_req_ready;
  assign any_acc = svc_acc | win_acc;
  assign acc_wr  = svc_acc ? svc_req_write : win_req_write;

  a_r1_tie_to_service: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req_valid |-> !win_req_ready);
  a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    any_acc |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !any_acc |=> !rsp_valid);
  a_r1_rsp_port: assert property (@(posedge clk) disable iff (!rst_n)
    any_acc |=> (rsp_port == $past(win_acc)));
  a_r5_window_base_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && win_req_write && win_req_addr[AW-1:3] == '0)
      |=> (rsp_err && $stable(win_base) && $stable(win_enable)));
  a_r8_unimp_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !acc_wr) |=> (rsp_unimp -> (rsp_rdata == '1)));
  a_r10_toggle_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_win_toggle |-> rsp_valid);
endmodule

bind bridge_csr_bank bcb_checker #(.IDX_W(IDX_W), .AW(AW), .DW(DW)) u_bcb_checker (
  .clk(clk), .rst_n(rst_n),
  .svc_req_valid(svc_req_valid), .svc_req_ready(svc_req_ready),
  .svc_req_write(svc_req_write),
  .win_req_valid(win_req_valid), .win_req_ready(win_req_ready),
  .win_req_write(win_req_write), .win_req_addr(win_req_addr),
  .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .rsp_unimp(rsp_unimp), .win_enable(win_enable),
  .win_base(win_base), .ctl_win_toggle(ctl_win_toggle)
);

// File: tb/test_bridge_csr_bank.sv
module test_bridge_csr_bank;
  localparam logic [63:0] AMASK  = 64'h0003_FFFF_FFF0_0000;
  localparam logic [63:0] B2MASK = 64'h0003_FFFF_0000_0000;
  localparam logic [63:0] BINIT  = 64'h0003_FFFE_8000_0001;
  localparam logic [63:0] ONES   = '1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        svc_req_valid = 0, svc_req_write = 0, win_req_valid = 0, win_req_write = 0;
  logic [4:0]  svc_req_index = '0;
  logic [7:0]  win_req_addr = '0;
  logic [63:0] svc_req_wdata = '0, win_req_wdata = '0;
  logic [4:0]  irq_src = '0;
  logic        svc_req_ready, win_req_ready, rsp_valid, rsp_port, rsp_err, rsp_unimp;
  logic        win_enable, ctl_win_toggle;
  logic [63:0] rsp_rdata, win_base;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_fault = '0, m_ctl = '0, m_base = BINIT & (AMASK | 64'd1), m_base2 = '0;
  logic [63:0] m_plain [4] = '{default: '0};

  always #4 clk = ~clk;

  bridge_csr_bank i_bridge_csr_bank (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int slot_of(int idx);
    case (idx)
      'h06: return 0;
      'h07: return 1;
      'h0F: return 2;
      'h14: return 3;
      default: return -1;
    endcase
  endfunction

  // Reference model of one access; updates shadow state, returns expected response.
  task automatic model(input bit from_win, input bit wr, input int idx, input logic [63:0] d,
                       output logic [63:0] e_rd, output bit e_err, output bit e_un, output bit e_tog);
    logic [63:0] old_ctl;
    int sl;
    old_ctl = m_ctl; e_rd = '0; e_err = 0; e_un = 0;
    sl = slot_of(idx);
    if (wr) begin
      if (sl >= 0) m_plain[sl] = d;
      else case (idx)
        'h00: m_fault = d;
        'h01: m_fault = m_fault & d;
        'h02: m_fault = m_fault | d;
        'h0A: if (from_win) e_err = 1; else m_base = d & (AMASK | 64'd1);
        'h0B: m_base2 = d & B2MASK;
        'h0E: m_ctl = d;
        'h12: m_ctl = m_ctl | d;
        'h13: m_ctl = m_ctl & ~d;
        'h15: e_err = 1;
        default: e_un = 1;
      endcase
    end else begin
      if (sl >= 0) e_rd = m_plain[sl];
      else case (idx)
        'h00: e_rd = m_fault;
        'h0A: e_rd = m_base;
        'h0B: e_rd = m_base2;
        'h0E: e_rd = m_ctl;
        'h15: e_rd = {27'd0, irq_src, 32'd0};
        default: begin e_rd = ONES; e_un = 1; end
      endcase
    end
    e_tog = old_ctl[62] ^ m_ctl[62];
  endtask

  task automatic bus_op(input bit from_win, input bit wr, input int a, input logic [63:0] d);
    @(negedge clk);
    if (from_win) begin
      win_req_valid = 1; win_req_write = wr; win_req_addr = a[7:0]; win_req_wdata = d;
    end else begin
      svc_req_valid = 1; svc_req_write = wr; svc_req_index = a[4:0]; svc_req_wdata = d;
    end
    @(posedge clk);
    @(negedge clk);
    svc_req_valid = 0; win_req_valid = 0;
  endtask

  // a = service index, or window byte address
  task automatic run_op(input string req, input bit from_win, input bit wr, input int a,
                        input logic [63:0] d);
    logic [63:0] e_rd; bit e_err, e_un, e_tog;
    int idx;
    idx = from_win ? ((a >> 3) + 'h0A) : a;
    model(from_win, wr, idx, d, e_rd, e_err, e_un, e_tog);
    bus_op(from_win, wr, a, d);
    chk({req, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " R1 rsp_port"}, 64'(rsp_port), 64'(from_win));
    chk({req, " rdata"}, rsp_rdata, e_rd);
    chk({req, " err"}, 64'(rsp_err), 64'(e_err));
    chk({req, " R8 unimp"}, 64'(rsp_unimp), 64'(e_un));
    chk({req, " R10 toggle"}, 64'(ctl_win_toggle), 64'(e_tog));
    chk({req, " R9 win_enable"}, 64'(win_enable), 64'(m_base[0]));
    chk({req, " R9 win_base"}, win_base, m_base & AMASK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 toggle", 64'(ctl_win_toggle), 64'd0);
    chk("R11 win_enable", 64'(win_enable), 64'd1);
    chk("R11 win_base", win_base, 64'h0003_FFFE_8000_0000);
    rst_n = 1;
    chk("R1 svc ready", 64'(svc_req_ready), 64'd1);
    run_op("R11 base", 0, 0, 'h0A, '0);
    run_op("R11 ctl", 0, 0, 'h0E, '0);
    run_op("R11 fault", 0, 0, 'h00, '0);
    run_op("R11 plain", 0, 0, 'h14, '0);
    // R3 fault aliases
    run_op("R3 wr", 0, 1, 'h00, 64'hF0F0_F0F0_1234_5678);
    run_op("R3 and", 0, 1, 'h01, 64'hFF00_FF00_FFFF_0000);
    run_op("R3 or", 0, 1, 'h02, 64'h0000_000F_0000_0001);
    run_op("R3 rd", 0, 0, 'h00, '0);
    run_op("R8 R3 alias rd", 0, 0, 'h01, '0);
    // R4 / R10 control aliases
    run_op("R4 wr", 0, 1, 'h0E, 64'h0000_00FF_0000_00FF);
    run_op("R4 R10 set", 0, 1, 'h12, 64'h4000_0000_0000_0100);
    run_op("R4 R10 set again", 0, 1, 'h12, 64'h4000_0000_0000_0000);
    run_op("R4 R10 clr", 0, 1, 'h13, 64'h4000_0000_0000_000F);
    run_op("R4 rd", 0, 0, 'h0E, '0);
    run_op("R10 direct", 0, 1, 'h0E, 64'h4000_0000_0000_0000);
    run_op("R8 R4 alias rd", 0, 0, 'h13, '0);
    // R5 / R6 / R9 base
    run_op("R6 R9 base", 0, 1, 'h0A, ONES);
    run_op("R6 base rd", 0, 0, 'h0A, '0);
    run_op("R5 win base wr", 1, 1, 'h00, 64'h0000_0000_0000_0000);
    run_op("R5 base kept", 0, 0, 'h0A, '0);
    run_op("R9 disable", 0, 1, 'h0A, 64'h0001_0000_0010_0000);
    run_op("R6 base2", 0, 1, 'h0B, ONES);
    run_op("R6 base2 rd win", 1, 0, 'h08, '0);
    // R7 interrupt status
    @(negedge clk); irq_src = 5'b10110;
    @(negedge clk);
    run_op("R7 rd", 0, 0, 'h15, '0);
    run_op("R2 R7 rd win", 1, 0, 'h5F, '0);
    run_op("R7 wr", 0, 1, 'h15, ONES);
    run_op("R7 rd after wr", 0, 0, 'h15, '0);
    // R8 unimplemented
    run_op("R8 rd", 0, 0, 'h03, '0);
    run_op("R8 wr", 0, 1, 'h03, 64'h1234);
    run_op("R8 rd again", 0, 0, 'h03, '0);
    run_op("R2 R8 over top", 1, 0, 'hB0, '0);
    run_op("R2 R8 over top wr", 1, 1, 'hFF, ONES);
    // R2 window mapping / R12 plain
    run_op("R2 R12 win wr", 1, 1, 'h53, 64'hDEAD_BEEF_0BAD_F00D);
    run_op("R12 svc rd", 0, 0, 'h14, '0);
    run_op("R12 wr7", 0, 1, 'h07, 64'h0123_4567_89AB_CDEF);
    run_op("R12 rd7", 0, 0, 'h07, '0);
    // R1 tie: service first, window next cycle
    begin
      logic [63:0] e1, e2; bit x1, x2, x3;
      @(negedge clk);
      svc_req_valid = 1; svc_req_write = 0; svc_req_index = 5'h0E;
      win_req_valid = 1; win_req_write = 0; win_req_addr = 8'h00;
      #1 chk("R1 win held off", 64'(win_req_ready), 64'd0);
      model(0, 0, 'h0E, '0, e1, x1, x2, x3);
      model(1, 0, 'h0A, '0, e2, x1, x2, x3);
      @(posedge clk); @(negedge clk);
      chk("R1 tie svc rsp", 64'(rsp_valid), 64'd1);
      chk("R1 tie svc port", 64'(rsp_port), 64'd0);
      chk("R1 tie svc data", rsp_rdata, e1);
      svc_req_valid = 0;
      #1 chk("R1 win ready", 64'(win_req_ready), 64'd1);
      @(posedge clk); @(negedge clk);
      chk("R1 tie win port", 64'(rsp_port), 64'd1);
      chk("R1 tie win data", rsp_rdata, e2);
      win_req_valid = 0;
      @(posedge clk); @(negedge clk);
      chk("R1 idle no rsp", 64'(rsp_valid), 64'd0);
    end
    // constrained random
    for (int n = 0; n < 600; n++) begin
      int pick [15] = '{'h00, 'h01, 'h02, 'h06, 'h07, 'h0A, 'h0B, 'h0E, 'h0F,
                        'h12, 'h13, 'h14, 'h15, 'h03, 'h1F};
      int idx, a;
      bit fw, wr;
      logic [63:0] d;
      fw = ($urandom % 3) == 0;
      wr = $urandom % 2;
      idx = ($urandom % 10 < 7) ? pick[$urandom % 15] : int'($urandom % 32);
      d = {$urandom, $urandom};
      if ($urandom % 4 == 0) d[62] = ~m_ctl[62];
      if (fw) a = (idx >= 'h0A) ? (((idx - 'h0A) << 3) | int'($urandom % 8)) : int'($urandom % 256);
      else a = idx;
      run_op("R1 R2 R3 R4 R5 R6 R7 R8 R12 random", fw, wr, a, d);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule